// File: doc/BRIEF.md
# Serial reflected CRC-16 engine

This block computes a 16-bit CRC over a byte stream with the generator polynomial 0x8005. The engine is bit-serial: each accepted byte passes through a 16-bit linear feedback shift register one bit per clock. Throughput is therefore one byte every eight clocks, and the message is never buffered. The same register serves two parameter sets, chosen per message. The plain set feeds every byte most significant bit first and reports the register untouched. The reflected set feeds every byte least significant bit first, mirrors the final register end to end and inverts every bit of it.

A message begins with a one-cycle `start` pulse. The pulse clears the register and captures the mode. Bytes then arrive over a valid/ready handshake, and the final byte is marked with `in_last`. One cycle after that byte's eighth bit, the result appears on `crc_out` together with a single-cycle `done` strobe. The result stays on `crc_out` until a later message completes. A `start` that arrives while a message is in progress abandons that message and begins a fresh one.

Top module: `crc16_serial`

## Requirements
- R1: Each bit step computes a feedback bit equal to the old register bit 15 XOR the data bit. The register shifts up by one, with the feedback bit entering bit 0 and also XORed into the values arriving at bits 2 and 15 (polynomial 0x8005).
- R2: A `start` pulse loads the register with 0x0000, so no state carries over from any earlier message.
- R3: In plain mode (`mode_refl`=0) every byte is fed bit 7 first, and `crc_out` equals the final register with no mask. For the nine ASCII bytes "123456789" the result is 0xFEE8.
- R4: In reflected mode (`mode_refl`=1) every byte is fed bit 0 first. The final register is mirrored (bit 15 to bit 0 and so on) and then XORed once with 0xFFFF. For "123456789" the result is 0x44C2.
- R5: `in_ready` is high only while a message is open and no byte is being shifted. A byte is accepted on an edge where `in_valid` and `in_ready` are both high. `in_ready` is then low for the next 7 cycles, so a following byte can be accepted 8 clocks after the previous one.
- R6: `done` goes high for exactly one cycle, starting 8 clocks after the edge that accepted the last byte. `crc_out` takes its new value on that same edge and holds it until the next `done`.
- R7: `mode_refl` is sampled only on the `start` edge. Changes to it during a message have no effect on the result.
- R8: A `start` while bytes are being shifted aborts that message. The result then depends only on the bytes sent after the new start.
- R9: After reset, and again after every `done`, `in_ready` is low and `in_valid` is ignored until the next `start`. After reset, `done` is 0 and `crc_out` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a message, clears the register and samples the mode |
| mode_refl | input | 1 | 0 = plain parameter set, 1 = reflected parameter set |
| in_valid | input | 1 | A byte is offered on in_data |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | The offered byte ends the message |
| in_ready | output | 1 | The engine can take a byte this cycle |
| crc_out | output | 16 | Result of the most recently finished message |
| done | output | 1 | One-cycle strobe when crc_out updates |

## Verification
Each byte is driven on a falling edge and taken on the next rising edge. From there, `in_ready` must read low on the following seven falling edges and high again on the eighth, unless the byte was the last one. For a last byte, `done` and the new `crc_out` must appear on the ninth falling edge after acceptance and nowhere earlier. The bench samples every one of these edges relative to the acceptance edge, so a result that comes one cycle early or late fails. It compares values against two software models: a shift-left model for the plain set, and a shift-right model with the mirrored polynomial 0xA001 for the reflected set. It also checks the two fixed results given in the requirements.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    typedef enum logic {
        MODE_PLAIN = 1'b0,
        MODE_REFL  = 1'b1
    } crc_mode_e;

endpackage

// File: rtl/crc16_bit_step.sv
module crc16_bit_step #(
    parameter int          W    = 16,
    parameter logic [15:0] POLY = 16'h8005
) (
    input  logic [W-1:0] cur,
    input  logic         bit_in,
    output logic [W-1:0] nxt
);
    logic fb;

    always_comb begin
        fb  = cur[W-1] ^ bit_in;
        nxt = {cur[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : '0);
    end

endmodule

// File: rtl/crc16_finish.sv
module crc16_finish #(
    parameter int          W      = 16,
    parameter logic [15:0] XOROUT = 16'hFFFF
) (
    input  logic [W-1:0] raw,
    input  logic         refl,
    output logic [W-1:0] res
);
    logic [W-1:0] mirrored;

    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign mirrored[i] = raw[W-1-i];
    end

    assign res = refl ? (mirrored ^ XOROUT[W-1:0]) : raw;

endmodule

// File: rtl/crc16_serial.sv
module crc16_serial
    import crc16_pkg::*;
#(
    parameter int          W      = 16,
    parameter logic [15:0] POLY   = 16'h8005,
    parameter logic [15:0] INIT   = 16'h0000,
    parameter logic [15:0] XOROUT = 16'hFFFF,
    parameter int          BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_refl,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic [W-1:0]      crc_out,
    output logic              done
);
    localparam int CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic              armed;
        crc_mode_e         mode;
        logic [W-1:0]      lfsr;
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  left;
        logic              last;
        logic              fin;
        logic [W-1:0]      res;
        logic              done;
    } state_t;

    state_t            st_d, st_q;
    logic              accept;
    logic [BYTE_W-1:0] byte_rev;
    logic [BYTE_W-1:0] byte_ord;
    logic              step_bit;
    logic [W-1:0]      lfsr_step;
    logic [W-1:0]      final_val;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_byte_rev
        assign byte_rev[i] = in_data[BYTE_W-1-i];
    end

    assign byte_ord = (st_q.mode == MODE_REFL) ? byte_rev : in_data;
    assign in_ready = st_q.armed && (st_q.left == '0) && !st_q.fin;
    assign accept   = in_ready && in_valid && !start;
    assign step_bit = accept ? byte_ord[BYTE_W-1] : st_q.sh[BYTE_W-1];

    crc16_bit_step #(.W(W), .POLY(POLY)) u_step (
        .cur    (st_q.lfsr),
        .bit_in (step_bit),
        .nxt    (lfsr_step)
    );

    crc16_finish #(.W(W), .XOROUT(XOROUT)) u_finish (
        .raw  (st_q.lfsr),
        .refl (st_q.mode == MODE_REFL),
        .res  (final_val)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.armed = 1'b1;
            st_d.mode  = mode_refl ? MODE_REFL : MODE_PLAIN;
            st_d.lfsr  = INIT[W-1:0];
            st_d.left  = '0;
            st_d.last  = 1'b0;
            st_d.fin   = 1'b0;
        end else if (st_q.fin) begin
            st_d.res   = final_val;
            st_d.done  = 1'b1;
            st_d.fin   = 1'b0;
            st_d.armed = 1'b0;
        end else if (accept) begin
            st_d.lfsr = lfsr_step;
            st_d.sh   = byte_ord << 1;
            st_d.left = CNT_W'(BYTE_W - 1);
            st_d.last = in_last;
        end else if (st_q.left != '0) begin
            st_d.lfsr = lfsr_step;
            st_d.sh   = st_q.sh << 1;
            st_d.left = st_q.left - CNT_W'(1);
            if (st_q.left == CNT_W'(1) && st_q.last) begin
                st_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_out = st_q.res;
    assign done    = st_q.done;

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(crc_out));

    assert_ready_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !start) |=> !in_ready);

    assert_mode_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(st_q.mode));

    assert_start_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (in_ready && !done));

    assert_closed_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

endmodule

// File: tb/crc16_serial_bench.sv
`timescale 1ns/1ps
module crc16_serial_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode_refl = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic [15:0] crc_out;
    logic        done;

    int checks = 0;
    int failures = 0;
    logic [7:0] msg [0:15];
    int msg_len = 0;

    always #5 clk = ~clk;

    crc16_serial u_crc16_serial (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode_refl (mode_refl),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .crc_out   (crc_out),
        .done      (done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_plain(input int n);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < n; i++) begin
            c = c ^ {msg[i], 8'h00};
            for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
        end
        return c;
    endfunction

    function automatic logic [15:0] model_refl(input int n);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < n; i++) begin
            c = c ^ {8'h00, msg[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
        end
        return c ^ 16'hFFFF;
    endfunction

    task automatic load_digits();
        for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
        msg_len = 9;
    endtask

    task automatic do_start(input bit refl);
        @(negedge clk);
        start = 1'b1;
        mode_refl = refl;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Drives one byte and checks the ready/done timing around it (R5, R6).
    task automatic send_byte(input logic [7:0] b, input bit last, input logic [15:0] exp_crc);
        int w = 0;
        while (!in_ready && w < 40) begin
            @(negedge clk);
            w++;
        end
        in_valid = 1'b1;
        in_data = b;
        in_last = last;
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
        for (int k = 0; k < 7; k++) begin
            chk(!in_ready, "R5 ready low while shifting", 32'(in_ready), 0);
            chk(!done, "R6 no early done", 32'(done), 0);
            @(negedge clk);
        end
        chk(in_ready == !last, "R5 ready after eight clocks", 32'(in_ready), 32'(!last));
        chk(!done, "R6 no early done", 32'(done), 0);
        if (last) begin
            @(negedge clk);
            chk(done, "R6 done on ninth edge", 32'(done), 1);
            chk(crc_out == exp_crc, "R6 result with done", 32'(crc_out), 32'(exp_crc));
            @(negedge clk);
            chk(!done, "R6 done single cycle", 32'(done), 0);
            chk(!in_ready, "R9 closed after done", 32'(in_ready), 0);
        end
    endtask

    task automatic run_msg(input bit refl, input logic [15:0] exp_crc);
        do_start(refl);
        for (int i = 0; i < msg_len; i++) send_byte(msg[i], i == msg_len - 1, exp_crc);
    endtask

    task automatic t_reset();
        chk(!in_ready, "R9 reset ready", 32'(in_ready), 0);
        chk(!done, "R9 reset done", 32'(done), 0);
        chk(crc_out == 16'h0000, "R9 reset crc", 32'(crc_out), 0);
    endtask

    task automatic t_plain_digits();
        load_digits();
        chk(model_plain(9) == 16'hFEE8, "R3 model check", 32'(model_plain(9)), 32'hFEE8);
        run_msg(1'b0, 16'hFEE8);
        chk(crc_out == 16'hFEE8, "R1 R3 plain digits", 32'(crc_out), 32'hFEE8);
    endtask

    task automatic t_refl_digits();
        load_digits();
        chk(model_refl(9) == 16'h44C2, "R4 model check", 32'(model_refl(9)), 32'h44C2);
        run_msg(1'b1, 16'h44C2);
        chk(crc_out == 16'h44C2, "R4 reflected digits", 32'(crc_out), 32'h44C2);
    endtask

    task automatic t_single_bytes();
        logic [7:0] pats [0:3] = '{8'h00, 8'hFF, 8'h80, 8'h01};
        for (int p = 0; p < 4; p++) begin
            msg[0] = pats[p];
            msg_len = 1;
            run_msg(1'b0, model_plain(1));
            chk(crc_out == model_plain(1), "R1 R3 single byte plain", 32'(crc_out), 32'(model_plain(1)));
            run_msg(1'b1, model_refl(1));
            chk(crc_out == model_refl(1), "R4 single byte reflected", 32'(crc_out), 32'(model_refl(1)));
        end
    endtask

    task automatic t_repeat_start();
        for (int i = 0; i < 5; i++) msg[i] = 8'hA5 ^ 8'(i * 37);
        msg_len = 5;
        run_msg(1'b1, model_refl(5));
        run_msg(1'b1, model_refl(5));
        chk(crc_out == model_refl(5), "R2 no carry-over", 32'(crc_out), 32'(model_refl(5)));
    endtask

    task automatic t_mode_hold();
        logic [15:0] exp_crc;
        for (int i = 0; i < 4; i++) msg[i] = 8'h3C + 8'(i * 11);
        msg_len = 4;
        exp_crc = model_refl(4);
        do_start(1'b1);
        for (int i = 0; i < msg_len; i++) begin
            mode_refl = i[0];
            send_byte(msg[i], i == msg_len - 1, exp_crc);
        end
        chk(crc_out == exp_crc, "R7 mode latched at start", 32'(crc_out), 32'(exp_crc));
    endtask

    task automatic t_abort();
        do_start(1'b0);
        in_valid = 1'b1;
        in_data = 8'h5A;
        in_last = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        start = 1'b1;
        mode_refl = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(in_ready, "R8 start reopens mid-byte", 32'(in_ready), 1);
        msg[0] = 8'hC3;
        msg[1] = 8'h7E;
        msg_len = 2;
        for (int i = 0; i < 2; i++) send_byte(msg[i], i == 1, model_plain(2));
        chk(crc_out == model_plain(2), "R8 abort discards old bytes", 32'(crc_out), 32'(model_plain(2)));
    endtask

    task automatic t_ignore_closed();
        logic [15:0] held = crc_out;
        in_valid = 1'b1;
        in_data = 8'hEE;
        in_last = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk(!in_ready && !done, "R9 closed engine ignores input", 32'({in_ready, done}), 0);
        end
        in_valid = 1'b0;
        in_last = 1'b0;
        chk(crc_out == held, "R9 result unchanged while closed", 32'(crc_out), 32'(held));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ignore_closed();
        t_plain_digits();
        t_refl_digits();
        t_ignore_closed();
        t_single_bytes();
        t_repeat_start();
        t_mode_hold();
        t_abort();
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule